// File: doc/BRIEF.md
# Resource Request Command Sequencer

This block keeps a set of command banks, each able to hold up to a fixed number of slots. A slot describes one resource-state request: a target address, a data word, a few header bits, a flag saying whether the request expects a response, and an enable bit. Software fills slots and sets each bank's request count through a plain write port. It then pulses the bank's trigger bit. From that point the bank walks its slots in ascending order and places each enabled request, one at a time, on a shared valid/ready request bus that leads to the resource managers.

Several banks may run at the same time. They share the request bus through a round-robin arbiter. A request stays pending from its handshake until a response comes back carrying its bank and slot index. A fire-and-forget request is complete as soon as the handshake happens. No request is issued while another pending request holds the same address. The bank waits at that slot until the address is released.

When a bank has issued all of its requests and none is still pending, it raises its interrupt. The bank then stays closed until software clears the interrupt. A response that matches no pending request sets a sticky error flag.

Top module: `cmdseq_top`

## Requirements
- R1: While reset is low and right after it is released, `irq` is all zero, `req_valid` is 0 and `err` is 0.
- R2: After a trigger, a bank issues exactly those slots whose enable bit is 1 and whose index is below the bank's count, in ascending slot order. Each request carries the stored address, data, header and response flag, plus its bank and slot index.
- R3: A fire-and-forget request completes only at a cycle where `req_valid` and `req_ready` are both 1. While `req_ready` is held low the request stays on the bus and the bank does not finish.
- R4: A request with its response flag set stays pending until `rsp_valid` is seen with its bank and slot index. Until then the bank's interrupt stays low.
- R5: A request is not issued while a pending request in any bank holds the same address. Once the pending request's response arrives, the stalled bank issues it.
- R6: Banks triggered together run concurrently. When two banks both have a request ready, the round-robin grants alternate between them, so consecutive issues come from different banks.
- R7: A bank raises `irq[b]` once all its requests are issued and none is pending. `irq[b]` stays 1 until `irq_clr[b]` is pulsed, and the bank issues nothing while it is 1.
- R8: A trigger that reaches a bank whose interrupt is still set has no effect. After the clear, a new trigger reissues the bank's requests.
- R9: A response whose bank and slot match no pending request sets `err`, and `err` stays 1 until reset.
- R10: A count value larger than the number of slots is treated as the number of slots. A count of 0 makes the bank finish without issuing anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_we | input | 1 | Slot write strobe |
| slot_bank | input | BW | Bank selected for the slot write |
| slot_idx | input | SW | Slot selected for the slot write |
| slot_addr | input | AW | Request address to store |
| slot_data | input | DW | Request data to store |
| slot_hdr | input | HW | Header bits to store |
| slot_need | input | 1 | 1 = response expected, 0 = fire-and-forget |
| slot_on | input | 1 | Slot enable |
| cnt_we | input | 1 | Count write strobe |
| cnt_bank | input | BW | Bank selected for the count write |
| cnt_val | input | CW | Number of slots to walk |
| trig | input | NUM_BANKS | Per-bank start pulse |
| irq_clr | input | NUM_BANKS | Per-bank interrupt clear pulse |
| irq | output | NUM_BANKS | Per-bank completion interrupt |
| req_valid | output | 1 | Request bus valid |
| req_ready | input | 1 | Request bus ready |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request data |
| req_hdr | output | HW | Request header |
| req_need | output | 1 | Request expects a response |
| req_bank | output | BW | Issuing bank index |
| req_slot | output | SW | Issuing slot index |
| rsp_valid | input | 1 | Response strobe |
| rsp_bank | input | BW | Bank index of the response |
| rsp_slot | input | SW | Slot index of the response |
| err | output | 1 | Sticky unmatched-response flag |

## Verification
The bench builds the block with its defaults: two banks of sixteen slots, 16-bit addresses and 32-bit data. With two banks it can trigger both at once, which covers cross-bank address blocking and the alternation of round-robin grants. With sixteen slots the count-saturation case can fill a bank completely and check that the walk ends at the last slot. A bench-side responder answers pending requests a cycle after they issue, or holds them back so that stalls and missing responses can be observed.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_RUN  = 2'd1,
        BK_DONE = 2'd2
    } bank_st_e;

endpackage

// File: rtl/cmdseq_rr_arb.sv
module cmdseq_rr_arb #(
    parameter  int N  = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] gnt
);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_t;

    arb_t q, d;
    logic [IW-1:0] pick;
    logic found;

    always_comb begin
        gnt   = '0;
        pick  = '0;
        found = 1'b0;
        // search starts one past the last granted requester
        for (int i = 1; i <= N; i++) begin
            if (!found && req[(int'(q.last) + i) % N]) begin
                found = 1'b1;
                gnt[(int'(q.last) + i) % N] = 1'b1;
                pick = IW'((int'(q.last) + i) % N);
            end
        end
        d = q;
        if (adv && found) begin
            d.last = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.last <= IW'(N - 1);
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cmdseq_bank.sv
module cmdseq_bank
    import cmdseq_pkg::*;
#(
    parameter  int SLOTS = 16,
    parameter  int AW    = 16,
    parameter  int DW    = 32,
    parameter  int HW    = 4,
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_slot,
    input  logic [SW-1:0]            wr_idx,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [HW-1:0]            wr_hdr,
    input  logic                     wr_need,
    input  logic                     wr_on,
    input  logic                     wr_cnt_en,
    input  logic [CW-1:0]            wr_cnt,
    input  logic                     trig,
    input  logic                     clr,
    input  logic                     blocked,
    input  logic                     fire,
    input  logic                     rsp_hit,
    input  logic [SW-1:0]            rsp_slot,
    output logic                     want,
    output logic [AW-1:0]            cur_addr,
    output logic [DW-1:0]            cur_data,
    output logic [HW-1:0]            cur_hdr,
    output logic                     cur_need,
    output logic [SW-1:0]            cur_slot,
    output logic [SLOTS-1:0]         pend_o,
    output logic [SLOTS-1:0][AW-1:0] addr_tab,
    output logic                     irq
);

    localparam logic [CW-1:0] FULL = CW'(SLOTS);

    typedef struct packed {
        bank_st_e                st;
        logic [CW-1:0]           ptr;
        logic [CW-1:0]           cnt;
        logic [SLOTS-1:0]        pend;
        logic [SLOTS-1:0]        on;
        logic [SLOTS-1:0]        need;
        logic [SLOTS-1:0][AW-1:0] addr;
        logic [SLOTS-1:0][DW-1:0] data;
        logic [SLOTS-1:0][HW-1:0] hdr;
    } bank_t;

    bank_t q, d;
    logic [SW-1:0] cur;
    logic live;

    always_comb begin
        cur  = q.ptr[SW-1:0];
        live = (q.st == BK_RUN) && (q.ptr < q.cnt);
        want = live && q.on[cur] && !blocked;

        d = q;
        if (wr_slot) begin
            d.addr[wr_idx] = wr_addr;
            d.data[wr_idx] = wr_data;
            d.hdr[wr_idx]  = wr_hdr;
            d.need[wr_idx] = wr_need;
            d.on[wr_idx]   = wr_on;
        end
        if (wr_cnt_en) begin
            d.cnt = (wr_cnt > FULL) ? FULL : wr_cnt;
        end
        if (rsp_hit) begin
            d.pend[rsp_slot] = 1'b0;
        end

        unique case (q.st)
            BK_IDLE: begin
                if (trig) begin
                    d.st  = BK_RUN;
                    d.ptr = '0;
                end
            end
            BK_RUN: begin
                if (live) begin
                    if (!q.on[cur]) begin
                        d.ptr = q.ptr + 1'b1;
                    end else if (fire) begin
                        if (q.need[cur]) begin
                            d.pend[cur] = 1'b1;
                        end
                        d.ptr = q.ptr + 1'b1;
                    end
                end else if (q.pend == '0) begin
                    d.st = BK_DONE;
                end
            end
            BK_DONE: begin
                if (clr) begin
                    d.st = BK_IDLE;
                end
            end
            default: d.st = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_addr = q.addr[cur];
    assign cur_data = q.data[cur];
    assign cur_hdr  = q.hdr[cur];
    assign cur_need = q.need[cur];
    assign cur_slot = cur;
    assign pend_o   = q.pend;
    assign addr_tab = q.addr;
    assign irq      = (q.st == BK_DONE);

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top #(
    parameter  int NUM_BANKS = 2,
    parameter  int SLOTS     = 16,
    parameter  int AW        = 16,
    parameter  int DW        = 32,
    parameter  int HW        = 4,
    localparam int BW        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int SW        = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW        = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_we,
    input  logic [BW-1:0]        slot_bank,
    input  logic [SW-1:0]        slot_idx,
    input  logic [AW-1:0]        slot_addr,
    input  logic [DW-1:0]        slot_data,
    input  logic [HW-1:0]        slot_hdr,
    input  logic                 slot_need,
    input  logic                 slot_on,
    input  logic                 cnt_we,
    input  logic [BW-1:0]        cnt_bank,
    input  logic [CW-1:0]        cnt_val,
    input  logic [NUM_BANKS-1:0] trig,
    input  logic [NUM_BANKS-1:0] irq_clr,
    output logic [NUM_BANKS-1:0] irq,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [AW-1:0]        req_addr,
    output logic [DW-1:0]        req_data,
    output logic [HW-1:0]        req_hdr,
    output logic                 req_need,
    output logic [BW-1:0]        req_bank,
    output logic [SW-1:0]        req_slot,
    input  logic                 rsp_valid,
    input  logic [BW-1:0]        rsp_bank,
    input  logic [SW-1:0]        rsp_slot,
    output logic                 err
);

    typedef struct packed {
        logic err;
    } top_t;

    top_t q, d;

    logic [NUM_BANKS-1:0]                     want, blk, gnt, hit;
    logic [NUM_BANKS-1:0][SLOTS-1:0]          pend;
    logic [NUM_BANKS-1:0][SLOTS-1:0][AW-1:0]  atab;
    logic [NUM_BANKS-1:0][AW-1:0]             c_addr;
    logic [NUM_BANKS-1:0][DW-1:0]             c_data;
    logic [NUM_BANKS-1:0][HW-1:0]             c_hdr;
    logic [NUM_BANKS-1:0]                     c_need;
    logic [NUM_BANKS-1:0][SW-1:0]             c_slot;
    logic                                     fire;

    assign fire = req_valid && req_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cmdseq_bank #(
            .SLOTS(SLOTS), .AW(AW), .DW(DW), .HW(HW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_slot  (slot_we && (slot_bank == BW'(b))),
            .wr_idx   (slot_idx),
            .wr_addr  (slot_addr),
            .wr_data  (slot_data),
            .wr_hdr   (slot_hdr),
            .wr_need  (slot_need),
            .wr_on    (slot_on),
            .wr_cnt_en(cnt_we && (cnt_bank == BW'(b))),
            .wr_cnt   (cnt_val),
            .trig     (trig[b]),
            .clr      (irq_clr[b]),
            .blocked  (blk[b]),
            .fire     (fire && gnt[b]),
            .rsp_hit  (hit[b]),
            .rsp_slot (rsp_slot),
            .want     (want[b]),
            .cur_addr (c_addr[b]),
            .cur_data (c_data[b]),
            .cur_hdr  (c_hdr[b]),
            .cur_need (c_need[b]),
            .cur_slot (c_slot[b]),
            .pend_o   (pend[b]),
            .addr_tab (atab[b]),
            .irq      (irq[b])
        );
    end

    cmdseq_rr_arb #(.N(NUM_BANKS)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (want),
        .adv  (fire),
        .gnt  (gnt)
    );

    // a bank's next request waits while any pending request targets its address
    always_comb begin
        blk = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int k = 0; k < NUM_BANKS; k++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (pend[k][s] && (atab[k][s] == c_addr[b])) begin
                        blk[b] = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        req_addr = '0;
        req_data = '0;
        req_hdr  = '0;
        req_need = 1'b0;
        req_bank = '0;
        req_slot = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (gnt[b]) begin
                req_addr = c_addr[b];
                req_data = c_data[b];
                req_hdr  = c_hdr[b];
                req_need = c_need[b];
                req_bank = BW'(b);
                req_slot = c_slot[b];
            end
        end
        req_valid = |want;
    end

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit[b] = rsp_valid && (rsp_bank == BW'(b)) && pend[b][rsp_slot];
        end
        d     = q;
        d.err = q.err || (rsp_valid && (hit == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign err = q.err;

endmodule

// File: rtl/cmdseq_top_chk.sv
module cmdseq_top_chk #(
    parameter int NB = 2,
    parameter int BW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [BW-1:0] req_bank,
    input logic [NB-1:0] irq,
    input logic [NB-1:0] irq_clr,
    input logic [NB-1:0] want,
    input logic [NB-1:0] gnt,
    input logic          err
);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!req_valid && (irq == '0) && !err));

    a_r6_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~want) == '0));

    a_r6_grant_when_wanted: assert property (@(posedge clk) disable iff (!rst_n)
        (want != '0) |-> (gnt != '0));

    a_r7_no_issue_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !irq[req_bank]);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    for (genvar b = 0; b < NB; b++) begin : g_irq
        a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[b] && !irq_clr[b]) |=> irq[b]);
    end

endmodule

bind cmdseq_top cmdseq_top_chk #(.NB(NUM_BANKS), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_bank (req_bank),
    .irq      (irq),
    .irq_clr  (irq_clr),
    .want     (want),
    .gnt      (gnt),
    .err      (err)
);

// File: tb/cmdseq_top_test.sv
module cmdseq_top_test;

    localparam int NB = 2;
    localparam int BW = 1;
    localparam int SW = 4;
    localparam int CW = 5;

    typedef struct packed {
        logic [3:0]  slot;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  hdr;
        logic        need;
        logic        on;
    } vec_t;

    // bank 0 load: slot 2 disabled, slot 5 beyond the count of 5
    localparam int   TBL_N   = 6;
    localparam int   TBL_CNT = 5;
    localparam vec_t TBL [TBL_N] = '{
        '{4'd0, 16'h0010, 32'h1111_0001, 4'h1, 1'b0, 1'b1},
        '{4'd1, 16'h0020, 32'h2222_0002, 4'h2, 1'b1, 1'b1},
        '{4'd2, 16'h0030, 32'h3333_0003, 4'h3, 1'b0, 1'b0},
        '{4'd3, 16'h0040, 32'h4444_0004, 4'h4, 1'b1, 1'b1},
        '{4'd4, 16'h0050, 32'h5555_0005, 4'h5, 1'b0, 1'b1},
        '{4'd5, 16'h0060, 32'h6666_0006, 4'h6, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          slot_we, slot_need, slot_on, cnt_we;
    logic [BW-1:0] slot_bank, cnt_bank;
    logic [SW-1:0] slot_idx;
    logic [15:0]   slot_addr;
    logic [31:0]   slot_data;
    logic [3:0]    slot_hdr;
    logic [CW-1:0] cnt_val;
    logic [NB-1:0] trig, irq_clr, irq;
    logic          req_valid, req_ready, req_need, err;
    logic [15:0]   req_addr;
    logic [31:0]   req_data;
    logic [3:0]    req_hdr;
    logic [BW-1:0] req_bank, rsp_bank;
    logic [SW-1:0] req_slot, rsp_slot;
    logic          rsp_valid;

    cmdseq_top uut (
        .clk(clk), .rst_n(rst_n),
        .slot_we(slot_we), .slot_bank(slot_bank), .slot_idx(slot_idx),
        .slot_addr(slot_addr), .slot_data(slot_data), .slot_hdr(slot_hdr),
        .slot_need(slot_need), .slot_on(slot_on),
        .cnt_we(cnt_we), .cnt_bank(cnt_bank), .cnt_val(cnt_val),
        .trig(trig), .irq_clr(irq_clr), .irq(irq),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_hdr(req_hdr), .req_need(req_need),
        .req_bank(req_bank), .req_slot(req_slot),
        .rsp_valid(rsp_valid), .rsp_bank(rsp_bank), .rsp_slot(rsp_slot),
        .err(err)
    );

    int checks = 0;
    int errors = 0;

    // bus monitor log
    logic [15:0] log_addr [128];
    logic [31:0] log_data [128];
    logic [3:0]  log_hdr  [128];
    logic        log_need [128];
    logic [BW-1:0] log_bank [128];
    logic [SW-1:0] log_slot [128];
    int          log_n = 0;

    // automatic responder queue
    logic [BW-1:0] rq_bank [128];
    logic [SW-1:0] rq_slot [128];
    int   q_tail = 0;
    int   q_head = 0;
    logic auto_rsp = 1'b1;
    int   man_cnt = 0;
    int   man_seen = 0;
    logic [BW-1:0] man_bank;
    logic [SW-1:0] man_slot;

    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            log_addr[log_n] <= req_addr;
            log_data[log_n] <= req_data;
            log_hdr[log_n]  <= req_hdr;
            log_need[log_n] <= req_need;
            log_bank[log_n] <= req_bank;
            log_slot[log_n] <= req_slot;
            log_n <= log_n + 1;
            if (req_need && auto_rsp) begin
                rq_bank[q_tail] <= req_bank;
                rq_slot[q_tail] <= req_slot;
                q_tail <= q_tail + 1;
            end
        end
    end

    always begin
        @(posedge clk);
        #1;
        rsp_valid = 1'b0;
        if (man_cnt != man_seen) begin
            rsp_valid = 1'b1;
            rsp_bank  = man_bank;
            rsp_slot  = man_slot;
            man_seen  = man_seen + 1;
        end else if (q_head != q_tail) begin
            rsp_valid = 1'b1;
            rsp_bank  = rq_bank[q_head];
            rsp_slot  = rq_slot[q_head];
            q_head    = q_head + 1;
        end
    end

    task automatic check_eq(input string rq, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic write_slot(input int b, input int s, input logic [15:0] a,
                              input logic [31:0] dt, input logic [3:0] h,
                              input logic nd, input logic en);
        @(posedge clk); #1;
        slot_we = 1'b1; slot_bank = BW'(b); slot_idx = SW'(s);
        slot_addr = a; slot_data = dt; slot_hdr = h; slot_need = nd; slot_on = en;
        @(posedge clk); #1;
        slot_we = 1'b0;
    endtask

    task automatic write_cnt(input int b, input int c);
        @(posedge clk); #1;
        cnt_we = 1'b1; cnt_bank = BW'(b); cnt_val = CW'(c);
        @(posedge clk); #1;
        cnt_we = 1'b0;
    endtask

    task automatic pulse_trig(input logic [NB-1:0] m);
        @(posedge clk); #1;
        trig = m;
        @(posedge clk); #1;
        trig = '0;
    endtask

    task automatic pulse_clr(input logic [NB-1:0] m);
        @(posedge clk); #1;
        irq_clr = m;
        @(posedge clk); #1;
        irq_clr = '0;
    endtask

    task automatic wait_irq(input logic [NB-1:0] m, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if ((irq & m) == m) break;
        end
    endtask

    task automatic respond(input int b, input int s);
        @(negedge clk);
        man_bank = BW'(b);
        man_slot = SW'(s);
        man_cnt  = man_cnt + 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        int start;
        int k;
        rst_n = 1'b0;
        slot_we = 1'b0; slot_bank = '0; slot_idx = '0; slot_addr = '0;
        slot_data = '0; slot_hdr = '0; slot_need = 1'b0; slot_on = 1'b0;
        cnt_we = 1'b0; cnt_bank = '0; cnt_val = '0;
        trig = '0; irq_clr = '0; req_ready = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "irq in reset", 64'(irq), 64'h0);
        check_eq("R1", "req_valid in reset", 64'(req_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "err after reset", 64'(err), 64'h0);
        check_eq("R1", "irq after reset", 64'(irq), 64'h0);

        // R2: table-driven load and walk of bank 0
        for (int i = 0; i < TBL_N; i++) begin
            write_slot(0, int'(TBL[i].slot), TBL[i].addr, TBL[i].data,
                       TBL[i].hdr, TBL[i].need, TBL[i].on);
        end
        write_cnt(0, TBL_CNT);
        start = log_n;
        pulse_trig(2'b01);
        wait_irq(2'b01, 200);
        k = start;
        for (int i = 0; i < TBL_N; i++) begin
            if (TBL[i].on && (int'(TBL[i].slot) < TBL_CNT)) begin
                check_eq("R2", "issued slot", 64'(log_slot[k]), 64'(TBL[i].slot));
                check_eq("R2", "issued addr", 64'(log_addr[k]), 64'(TBL[i].addr));
                check_eq("R2", "issued data/hdr/need",
                         {27'd0, log_data[k], log_hdr[k], log_need[k]},
                         {27'd0, TBL[i].data, TBL[i].hdr, TBL[i].need});
                k++;
            end
        end
        check_eq("R2", "issue count", 64'(log_n - start), 64'(k - start));
        check_eq("R7", "irq after walk", 64'(irq), 64'h1);

        // R8: trigger while interrupt set is ignored
        start = log_n;
        pulse_trig(2'b01);
        repeat (6) @(negedge clk);
        check_eq("R8", "issues after ignored trigger", 64'(log_n - start), 64'h0);
        check_eq("R7", "irq held", 64'(irq), 64'h1);
        pulse_clr(2'b01);
        @(negedge clk);
        check_eq("R7", "irq after clear", 64'(irq), 64'h0);
        pulse_trig(2'b01);
        wait_irq(2'b01, 200);
        check_eq("R8", "reissue after clear", 64'(log_n - start), 64'h4);
        pulse_clr(2'b01);

        // R3: fire-and-forget held by backpressure
        write_slot(1, 0, 16'h0100, 32'hABCD_0100, 4'h7, 1'b0, 1'b1);
        write_cnt(1, 1);
        @(posedge clk); #1;
        req_ready = 1'b0;
        start = log_n;
        pulse_trig(2'b10);
        repeat (5) @(negedge clk);
        check_eq("R3", "valid under backpressure", 64'(req_valid), 64'h1);
        check_eq("R3", "bank not done without handshake", 64'(irq), 64'h0);
        @(posedge clk); #1;
        req_ready = 1'b1;
        wait_irq(2'b10, 50);
        check_eq("R3", "done after handshake", 64'(irq), 64'h2);
        check_eq("R3", "single issue", 64'(log_n - start), 64'h1);
        pulse_clr(2'b10);

        // R4: response-expected request holds the bank
        auto_rsp = 1'b0;
        write_slot(1, 0, 16'h0180, 32'h0000_0180, 4'h1, 1'b1, 1'b1);
        pulse_trig(2'b10);
        repeat (8) @(negedge clk);
        check_eq("R4", "irq before response", 64'(irq), 64'h0);
        respond(1, 0);
        wait_irq(2'b10, 20);
        check_eq("R4", "irq after response", 64'(irq), 64'h2);
        pulse_clr(2'b10);

        // R5: same address in both banks
        write_slot(0, 0, 16'h0200, 32'h0000_0A00, 4'h2, 1'b1, 1'b1);
        write_cnt(0, 1);
        write_slot(1, 0, 16'h0200, 32'h0000_0B00, 4'h3, 1'b1, 1'b1);
        start = log_n;
        pulse_trig(2'b11);
        repeat (8) @(negedge clk);
        check_eq("R5", "one issue while address pending", 64'(log_n - start), 64'h1);
        respond(int'(log_bank[start]), 0);
        repeat (6) @(negedge clk);
        check_eq("R5", "second issue after release", 64'(log_n - start), 64'h2);
        check_eq("R5", "second issue from other bank",
                 64'(log_bank[start + 1] != log_bank[start]), 64'h1);
        respond(int'(log_bank[start + 1]), 0);
        wait_irq(2'b11, 20);
        check_eq("R5", "both banks done", 64'(irq), 64'h3);
        pulse_clr(2'b11);
        auto_rsp = 1'b1;

        // R6: concurrent banks alternate on the bus
        for (int s = 0; s < 3; s++) begin
            write_slot(0, s, 16'h0300 + 16'(s), 32'h0300 + 32'(s), 4'h0, 1'b0, 1'b1);
            write_slot(1, s, 16'h0400 + 16'(s), 32'h0400 + 32'(s), 4'h0, 1'b0, 1'b1);
        end
        write_cnt(0, 3);
        write_cnt(1, 3);
        start = log_n;
        pulse_trig(2'b11);
        wait_irq(2'b11, 50);
        check_eq("R6", "total issues", 64'(log_n - start), 64'h6);
        for (int i = 1; i < 6; i++) begin
            check_eq("R6", "bank alternation",
                     64'(log_bank[start + i] != log_bank[start + i - 1]), 64'h1);
        end
        pulse_clr(2'b11);

        // R10: count above slot total saturates
        for (int s = 0; s < 16; s++) begin
            write_slot(1, s, 16'h0500 + 16'(s), 32'(s), 4'h0, 1'b0, 1'b1);
        end
        write_cnt(1, 31);
        start = log_n;
        pulse_trig(2'b10);
        wait_irq(2'b10, 100);
        check_eq("R10", "saturated issue count", 64'(log_n - start), 64'd16);
        check_eq("R10", "last slot", 64'(log_slot[start + 15]), 64'd15);
        pulse_clr(2'b10);
        write_cnt(1, 0);
        start = log_n;
        pulse_trig(2'b10);
        wait_irq(2'b10, 20);
        check_eq("R10", "zero count finishes", 64'(irq), 64'h2);
        check_eq("R10", "zero count issues nothing", 64'(log_n - start), 64'h0);
        pulse_clr(2'b10);

        // R9: unmatched response
        check_eq("R9", "err before stray response", 64'(err), 64'h0);
        respond(0, 9);
        repeat (3) @(negedge clk);
        check_eq("R9", "err after stray response", 64'(err), 64'h1);
        repeat (4) @(negedge clk);
        check_eq("R9", "err stays set", 64'(err), 64'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule